// File: doc/BRIEF.md
# Per-Bank DRAM Timing Guard

This block sits in the command path of a DRAM controller. It watches four independent banks. For each bank it records whether a row is open and how long ago that bank was activated or precharged. A command candidate arrives as a valid flag, an operation code, a bank index and an auto-precharge flag.

In the same cycle, through combinational logic, the block returns one verdict:

- **accept:** the command is legal and every timing gap has elapsed.
- **wait:** the command is legal but a timing gap is still open.
- **reject:** the command can never be legal in the present bank state.

A command counts as issued at the rising edge where it is valid and accepted. At that edge the block updates the bank state and restarts the relevant countdowns.

Four gaps are enforced, each given in clock cycles:

- activate to column access;
- precharge to activate;
- the minimum active time before a bank may be precharged;
- activate to activate on the same bank.

The four values live in loadable registers. After reset they hold the slower speed grade's counts.

A read or write may carry an auto-precharge flag. The bank then closes at once. Its internal precharge begins only when the minimum active time has also run out.

Top module: `dram_bank_guard`

## Requirements
- R1: After synchronous reset every bank is closed (`bank_open` = 0). The gap registers hold 6 (activate to column), 6 (precharge to activate), 18 (active time) and 24 (activate to activate).
- R2: Operation codes are 0 = activate, 1 = read, 2 = write, 3 = precharge. With `cmd_valid` high, exactly one of `cmd_ok`, `cmd_wait` and `cmd_reject` is high. With `cmd_valid` low, all three are low.
- R3: A read or write to a closed bank is rejected. An activate to an open bank is rejected. Neither is ever answered with wait.
- R4: A read or write to an open bank waits until the activate-to-column count of cycles has passed since that bank's activate, and is accepted from then on.
- R5: A precharge to an open bank waits until the active-time count of cycles has passed since that bank's activate. Issuing it closes the bank from the next cycle.
- R6: An activate to a closed bank is accepted only once two gaps have passed on that bank. The precharge-to-activate count must have passed since precharge began. The activate-to-activate count must have passed since the previous activate.
- R7: An issued read or write with `cmd_ap` high closes its bank from the next cycle. Its precharge begins at the later of two points: the issue cycle, and the bank's activate plus the active-time count.
- R8: A precharge to a closed bank is accepted and has no effect on any bank's state or timing.
- R9: A `cfg_load` pulse writes all four gap registers, and the new values govern commands issued from the next cycle on. A loaded value of 0 acts as 1.
- R10: Banks are independent: commands and timers of one bank never change the verdict for another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Write the four gap registers |
| cfg_rcd | input | 8 | Activate-to-column gap, cycles |
| cfg_rp | input | 8 | Precharge-to-activate gap, cycles |
| cfg_ras | input | 8 | Minimum active time, cycles |
| cfg_rc | input | 8 | Activate-to-activate gap, cycles |
| cmd_valid | input | 1 | Command candidate present |
| cmd_op | input | 2 | Operation code |
| cmd_bank | input | 2 | Target bank |
| cmd_ap | input | 1 | Auto-precharge request on read/write |
| cmd_ok | output | 1 | Legal and timed: issued at this edge |
| cmd_wait | output | 1 | Legal but a gap is still running |
| cmd_reject | output | 1 | Illegal in the current bank state |
| bank_open | output | 4 | Open state of each bank |

## Verification
The hardest situation to reach is a deferred auto-precharge: a column access with the auto-precharge flag that lands before the bank's active time has run out. Here the bank is already closed, but its precharge countdown has not yet started.

Directed sequences load short gap values and place the flagged read two cycles after the activate. They then poll the next activate, so that its acceptance cycle reveals where the hidden precharge began.

Long pseudo-random command streams then compare every verdict and the open vector against a timestamp-based model under both the reset values and loaded values.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    localparam int TW = 8;

    typedef enum logic [1:0] {
        OP_ACT = 2'd0,
        OP_RD  = 2'd1,
        OP_WR  = 2'd2,
        OP_PRE = 2'd3
    } op_e;

    typedef struct packed {
        logic [TW-1:0] rcd;
        logic [TW-1:0] rp;
        logic [TW-1:0] ras;
        logic [TW-1:0] rc;
    } gaps_s;

    typedef enum logic [1:0] {
        V_NONE   = 2'd0,
        V_OK     = 2'd1,
        V_WAIT   = 2'd2,
        V_REJECT = 2'd3
    } verdict_e;

    localparam logic [TW-1:0] RST_RCD = TW'(6);
    localparam logic [TW-1:0] RST_RP  = TW'(6);
    localparam logic [TW-1:0] RST_RAS = TW'(18);
    localparam logic [TW-1:0] RST_RC  = TW'(24);

    // Countdown start value for a gap of v cycles (0 treated as 1).
    function automatic logic [TW-1:0] start_of(input logic [TW-1:0] v);
        return (v == '0) ? '0 : v - TW'(1);
    endfunction

    function automatic logic [TW-1:0] step_down(input logic [TW-1:0] c);
        return (c == '0) ? '0 : c - TW'(1);
    endfunction

endpackage

// File: rtl/dbg_gap_regs.sv
module dbg_gap_regs
    import dbg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  gaps_s         load_val,
    output gaps_s         gaps
);

    always_ff @(posedge clk) begin
        if (rst) begin
            gaps.rcd <= RST_RCD;
            gaps.rp  <= RST_RP;
            gaps.ras <= RST_RAS;
            gaps.rc  <= RST_RC;
        end else if (load) begin
            gaps <= load_val;
        end
    end

endmodule

// File: rtl/dbg_bank.sv
module dbg_bank
    import dbg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  gaps_s gaps,
    input  logic  do_act,
    input  logic  do_col,
    input  logic  do_ap,
    input  logic  do_pre,
    output logic  is_open,
    output logic  act_rdy,
    output logic  col_rdy,
    output logic  pre_rdy
);

    logic          open_q;
    logic          pend_q;
    logic [TW-1:0] rcd_q;
    logic [TW-1:0] rp_q;
    logic [TW-1:0] ras_q;
    logic [TW-1:0] rc_q;
    logic          ras_done;
    logic          pre_begin;
    logic          ap_issue;

    assign ras_done  = (ras_q == '0);
    assign ap_issue  = do_col && do_ap;
    assign pre_begin = do_pre || (ap_issue && ras_done) || (pend_q && ras_done);

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            pend_q <= 1'b0;
            rcd_q  <= '0;
            rp_q   <= '0;
            ras_q  <= '0;
            rc_q   <= '0;
        end else begin
            rcd_q <= do_act    ? start_of(gaps.rcd) : step_down(rcd_q);
            ras_q <= do_act    ? start_of(gaps.ras) : step_down(ras_q);
            rc_q  <= do_act    ? start_of(gaps.rc)  : step_down(rc_q);
            rp_q  <= pre_begin ? start_of(gaps.rp)  : step_down(rp_q);

            if (do_act)
                open_q <= 1'b1;
            else if (do_pre || ap_issue)
                open_q <= 1'b0;

            if (ap_issue && !ras_done)
                pend_q <= 1'b1;
            else if (pend_q && ras_done)
                pend_q <= 1'b0;
        end
    end

    assign is_open = open_q;
    assign act_rdy = !open_q && !pend_q && (rp_q == '0) && (rc_q == '0);
    assign col_rdy = (rcd_q == '0);
    assign pre_rdy = ras_done;

    // R3: an activate only ever reaches a closed bank
    a_r3_act_closed: assert property (@(posedge clk) disable iff (rst)
        do_act |-> !open_q);
    // R4: column commands only reach an open bank
    a_r4_col_open: assert property (@(posedge clk) disable iff (rst)
        do_col |-> open_q);
    // R5: an explicit precharge closes the bank
    a_r5_pre_closes: assert property (@(posedge clk) disable iff (rst)
        do_pre |=> !open_q);
    // R7: auto-precharge closes the bank at once
    a_r7_ap_closes: assert property (@(posedge clk) disable iff (rst)
        ap_issue |=> !open_q);
    // R6: no activate while a deferred precharge is outstanding
    a_r6_no_act_pending: assert property (@(posedge clk) disable iff (rst)
        do_act |-> !pend_q);
    // R7: a deferred precharge resolves no later than the active time end
    a_r7_pend_resolves: assert property (@(posedge clk) disable iff (rst)
        (pend_q && ras_done) |=> !pend_q);

endmodule

// File: rtl/dbg_decide.sv
module dbg_decide
    import dbg_pkg::*;
#(
    parameter int NB = 4,
    localparam int BW = (NB > 1) ? $clog2(NB) : 1
)(
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [BW-1:0] cmd_bank,
    input  logic          cmd_ap,
    input  logic [NB-1:0] is_open,
    input  logic [NB-1:0] act_rdy,
    input  logic [NB-1:0] col_rdy,
    input  logic [NB-1:0] pre_rdy,
    output verdict_e      verdict,
    output logic [NB-1:0] do_act,
    output logic [NB-1:0] do_col,
    output logic [NB-1:0] do_pre,
    output logic          do_ap
);

    op_e  op;
    logic sel_open, sel_act, sel_col, sel_pre;

    assign op       = op_e'(cmd_op);
    assign sel_open = is_open[cmd_bank];
    assign sel_act  = act_rdy[cmd_bank];
    assign sel_col  = col_rdy[cmd_bank];
    assign sel_pre  = pre_rdy[cmd_bank];

    always_comb begin
        verdict = V_NONE;
        if (cmd_valid) begin
            unique case (op)
                OP_ACT:        verdict = sel_open ? V_REJECT : (sel_act ? V_OK : V_WAIT);
                OP_RD, OP_WR:  verdict = !sel_open ? V_REJECT : (sel_col ? V_OK : V_WAIT);
                OP_PRE:        verdict = (!sel_open || sel_pre) ? V_OK : V_WAIT;
                default:       verdict = V_NONE;
            endcase
        end
    end

    assign do_ap = cmd_ap;

    for (genvar b = 0; b < NB; b++) begin : g_issue
        logic hit;
        assign hit       = (verdict == V_OK) && (cmd_bank == BW'(b));
        assign do_act[b] = hit && (op == OP_ACT);
        assign do_col[b] = hit && ((op == OP_RD) || (op == OP_WR));
        assign do_pre[b] = hit && (op == OP_PRE) && is_open[b];
    end

endmodule

// File: rtl/dram_bank_guard.sv
module dram_bank_guard
    import dbg_pkg::*;
#(
    parameter int NB = 4,
    localparam int BW = (NB > 1) ? $clog2(NB) : 1
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_load,
    input  logic [TW-1:0] cfg_rcd,
    input  logic [TW-1:0] cfg_rp,
    input  logic [TW-1:0] cfg_ras,
    input  logic [TW-1:0] cfg_rc,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [BW-1:0] cmd_bank,
    input  logic          cmd_ap,
    output logic          cmd_ok,
    output logic          cmd_wait,
    output logic          cmd_reject,
    output logic [NB-1:0] bank_open
);

    gaps_s         gaps;
    gaps_s         load_val;
    verdict_e      verdict;
    logic [NB-1:0] act_rdy, col_rdy, pre_rdy;
    logic [NB-1:0] do_act, do_col, do_pre;
    logic          do_ap;

    assign load_val = '{rcd: cfg_rcd, rp: cfg_rp, ras: cfg_ras, rc: cfg_rc};

    dbg_gap_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .load     (cfg_load),
        .load_val (load_val),
        .gaps     (gaps)
    );

    dbg_decide #(.NB(NB)) u_decide (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_bank  (cmd_bank),
        .cmd_ap    (cmd_ap),
        .is_open   (bank_open),
        .act_rdy   (act_rdy),
        .col_rdy   (col_rdy),
        .pre_rdy   (pre_rdy),
        .verdict   (verdict),
        .do_act    (do_act),
        .do_col    (do_col),
        .do_pre    (do_pre),
        .do_ap     (do_ap)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        dbg_bank u_bank (
            .clk     (clk),
            .rst     (rst),
            .gaps    (gaps),
            .do_act  (do_act[b]),
            .do_col  (do_col[b]),
            .do_ap   (do_ap),
            .do_pre  (do_pre[b]),
            .is_open (bank_open[b]),
            .act_rdy (act_rdy[b]),
            .col_rdy (col_rdy[b]),
            .pre_rdy (pre_rdy[b])
        );
    end

    assign cmd_ok     = (verdict == V_OK);
    assign cmd_wait   = (verdict == V_WAIT);
    assign cmd_reject = (verdict == V_REJECT);

    // R2: one verdict per valid command, none otherwise
    a_r2_one_verdict: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $onehot({cmd_ok, cmd_wait, cmd_reject}));
    a_r2_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |-> !(cmd_ok || cmd_wait || cmd_reject));
    // R10: at most one bank is touched per cycle
    a_r10_single_bank: assert property (@(posedge clk) disable iff (rst)
        $onehot0(do_act | do_col | do_pre));
    // R3: reads and writes to a closed bank are never told to wait
    a_r3_no_wait_closed: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op != 2'd0 && cmd_op != 2'd3 && !bank_open[cmd_bank])
        |-> cmd_reject);

endmodule

// File: tb/dram_bank_guard_tb_top.sv
module dram_bank_guard_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_load = 1'b0;
    logic [7:0] cfg_rcd = '0, cfg_rp = '0, cfg_ras = '0, cfg_rc = '0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = '0;
    logic [1:0] cmd_bank = '0;
    logic       cmd_ap = 1'b0;
    logic       cmd_ok, cmd_wait, cmd_reject;
    logic [3:0] bank_open;

    always #2.5 clk = ~clk;

    dram_bank_guard dut_i (
        .clk(clk), .rst(rst), .cfg_load(cfg_load),
        .cfg_rcd(cfg_rcd), .cfg_rp(cfg_rp), .cfg_ras(cfg_ras), .cfg_rc(cfg_rc),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_ap(cmd_ap),
        .cmd_ok(cmd_ok), .cmd_wait(cmd_wait), .cmd_reject(cmd_reject),
        .bank_open(bank_open)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model: timestamps in cycles
    int  cyc = 0;
    int  t_rcd = 6, t_rp = 6, t_ras = 18, t_rc = 24;
    int  last_act [4];
    int  pre_at [4];
    bit  m_open [4];
    int  got_last;

    localparam int D_OK = 0, D_WAIT = 1, D_REJ = 2, D_NONE = 3;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int model_verdict(input bit v, input int op, input int b);
        if (!v) return D_NONE;
        case (op)
            0: begin
                if (m_open[b]) return D_REJ;
                if (cyc >= pre_at[b] + t_rp && cyc >= last_act[b] + t_rc) return D_OK;
                return D_WAIT;
            end
            1, 2: begin
                if (!m_open[b]) return D_REJ;
                if (cyc >= last_act[b] + t_rcd) return D_OK;
                return D_WAIT;
            end
            default: begin
                if (!m_open[b]) return D_OK;
                if (cyc >= last_act[b] + t_ras) return D_OK;
                return D_WAIT;
            end
        endcase
    endfunction

    function automatic string req_of(input int op, input int exp);
        if (exp == D_NONE) return "R2";
        if (exp == D_REJ) return "R3";
        case (op)
            0: return "R6";
            1, 2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic step(input bit v, input int op, input int b, input bit ap);
        int exp, got;
        int mo;
        @(negedge clk);
        cfg_load = 1'b0;
        cmd_valid = v; cmd_op = 2'(op); cmd_bank = 2'(b); cmd_ap = ap;
        #1;
        exp = model_verdict(v, op, b);
        got = cmd_ok ? D_OK : cmd_wait ? D_WAIT : cmd_reject ? D_REJ : D_NONE;
        if (int'(cmd_ok) + int'(cmd_wait) + int'(cmd_reject) > 1) got = 9;
        check(got == exp, req_of(op, exp), got, exp);
        mo = 0;
        for (int i = 0; i < 4; i++) if (m_open[i]) mo |= (1 << i);
        check(int'(bank_open) == mo, "R10 bank_open", int'(bank_open), mo);
        got_last = got;
        @(posedge clk);
        if (v && exp == D_OK) begin
            if (op == 0) begin
                m_open[b] = 1; last_act[b] = cyc;
            end else if (op == 3) begin
                if (m_open[b]) begin m_open[b] = 0; pre_at[b] = cyc; end
            end else if (ap) begin
                m_open[b] = 0;
                pre_at[b] = (cyc > last_act[b] + t_ras) ? cyc : last_act[b] + t_ras;
            end
        end
        cyc++;
    endtask

    task automatic load_cfg(input int a, input int p, input int s, input int c);
        @(negedge clk);
        cmd_valid = 1'b0;
        cfg_load = 1'b1;
        cfg_rcd = 8'(a); cfg_rp = 8'(p); cfg_ras = 8'(s); cfg_rc = 8'(c);
        @(posedge clk);
        t_rcd = (a == 0) ? 1 : a; t_rp = (p == 0) ? 1 : p;
        t_ras = (s == 0) ? 1 : s; t_rc = (c == 0) ? 1 : c;
        cyc++;
    endtask

    // repeat a command until accepted; returns acceptance cycle
    task automatic poll(input int op, input int b, input bit ap, output int at);
        at = -1;
        for (int k = 0; k < 100; k++) begin
            at = cyc;
            step(1, op, b, ap);
            if (got_last == D_OK) break;
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(0, 0, 0, 0);
    endtask

    task automatic random_run(input int n);
        for (int k = 0; k < n; k++)
            step(($urandom_range(0, 7) != 0), int'($urandom_range(0, 3)),
                 int'($urandom_range(0, 3)), ($urandom_range(0, 2) == 0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int ta, tb, tx;
        for (int i = 0; i < 4; i++) begin
            last_act[i] = -1000; pre_at[i] = -1000; m_open[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        check(bank_open == 4'd0, "R1 reset closed", int'(bank_open), 0);
        @(posedge clk); cyc = 0;

        // R1 / R4 / R5 / R6 with reset gap values
        ta = cyc; step(1, 0, 0, 0);
        poll(1, 0, 0, tb);
        check(tb - ta == 6, "R1 R4 rcd reset value", tb - ta, 6);
        poll(3, 0, 0, tb);
        check(tb - ta == 18, "R1 R5 ras reset value", tb - ta, 18);
        poll(0, 0, 0, tb);
        check(tb - ta == 24, "R1 R6 rc reset value", tb - ta, 24);

        // R3: illegal pairs
        step(1, 1, 1, 0);
        check(got_last == D_REJ, "R3 read closed", got_last, D_REJ);
        step(1, 0, 0, 0);
        check(got_last == D_REJ, "R3 act open", got_last, D_REJ);

        // R10: another bank activates at once
        step(1, 0, 1, 0);
        check(got_last == D_OK, "R10 independent act", got_last, D_OK);

        // R8: precharge to closed bank is a no-op
        step(1, 3, 3, 0);
        check(got_last == D_OK, "R8 pre closed accepted", got_last, D_OK);
        step(1, 0, 3, 0);
        check(got_last == D_OK, "R8 act after no-op pre", got_last, D_OK);

        idle(40);
        // R9: short gaps
        load_cfg(2, 3, 10, 4);
        idle(2);
        // R7 deferred: act, flagged read after 2 cycles
        ta = cyc; step(1, 0, 2, 0);
        poll(1, 2, 1, tb);
        check(tb - ta == 2, "R9 R4 loaded rcd", tb - ta, 2);
        step(1, 2, 2, 0);
        check(got_last == D_REJ, "R7 bank closed after ap", got_last, D_REJ);
        poll(0, 2, 0, tx);
        check(tx - ta == 13, "R7 deferred precharge", tx - ta, 13);
        // R7 immediate: flagged write after active time
        ta = cyc;
        idle(11);
        step(1, 2, 2, 1);
        tb = cyc - 1;
        poll(0, 2, 0, tx);
        check(tx - tb == 3, "R7 immediate precharge", tx - tb, 3);

        random_run(3000);
        idle(40);
        // R9: zero acts as one
        load_cfg(0, 0, 0, 0);
        ta = cyc; step(1, 0, 0, 0);
        if (got_last != D_OK) poll(0, 0, 0, ta);
        poll(1, 0, 0, tb);
        check(tb - ta == 1, "R9 zero gap", tb - ta, 1);
        random_run(2000);
        idle(40);
        load_cfg(6, 6, 18, 24);
        random_run(4000);
        load_cfg(3, 5, 8, 9);
        idle(30);
        random_run(4000);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule